// File: doc/BRIEF.md
# Keyed Reset Controller

This block generates the software-requested reset outputs of a chip and keeps a record of why the processor was last reset. Software reaches it through three 32-bit locations on a simple register bus: a write-only command word at offset 0x0, a read-only status word at offset 0x4 and a read/write mode word at offset 0x8. A command or mode write has an effect only when its top byte carries the unlock key 0xA5.

A command can ask for a processor reset, a peripheral reset and a drive of the active-low external reset line, in any combination. The chosen outputs are held for 2^(N+1) ticks of a slow-clock enable, where N is a mode field. The external reset line is also watched through a synchronizer. A falling edge on it sets a sticky flag, which can raise an interrupt, and it can optionally start a user reset. Power-up, core wake-up and watchdog events come in as one-cycle pulses and are recorded as reset causes.

Top module: `rstctl_top`

## Requirements
- R1: Bits 31:24 of a write to offset 0x0 or 0x8 must equal 0xA5. With any other value the write changes nothing: no reset output, no busy flag and no change to the mode word.
- R2: A keyed write to offset 0x0 requests a processor reset when bit 0 is 1, a peripheral reset when bit 2 is 1 and a low drive on the external line when bit 3 is 1. A keyed command with all three bits at 0 has no effect. While a command runs, status bit 17 (busy) reads 1.
- R3: The requested outputs and the busy flag rise on the clock edge that takes the command. They fall together after exactly 2^(N+1) further edges on which slow_tick is 1. N is mode bits 11:8, sampled when the command is taken.
- R4: A command that arrives while busy reads 1 is ignored. It does not add outputs and does not extend the running one.
- R5: Status bit 0 is set by a falling edge of the synchronized external line. It stays set until the status word is read, and then clears. If a read and a new edge fall on the same cycle, the flag stays set.
- R6: Status bit 16 shows the external line after a two-flop synchronizer. It therefore follows the pin two clock edges late.
- R7: irq_o is 1 exactly while mode bit 4 is 1 and status bit 0 is 1.
- R8: When mode bit 0 is 1, a low synchronized external line holds proc_rst_o and periph_rst_o at 1, and a falling edge records cause 4. When mode bit 0 is 0, the line is only flagged in status bit 0.
- R9: Status bits 10:8 hold the cause of the last processor reset: 0 power-up, 1 core wake-up, 2 watchdog, 3 software command with bit 0 set, 4 external line. On a tie the order from highest to lowest is power-up, wake-up, watchdog, external line, software.
- R10: por_pulse, like rst_n, clears the mode word, the sticky flag and any running command, and sets the cause to 0. Wake-up and watchdog pulses leave the mode word unchanged.
- R11: The stretch counter advances only on edges where slow_tick is 1.
- R12: After reset, the outputs are idle (proc_rst_o 0, periph_rst_o 0, ext_rst_n_o 1, irq_o 0). The mode word reads 0, and the status word reads 0x00010000 with the line high. Offset 0x0 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| slow_tick | input | 1 | Slow-clock enable that paces the reset stretch |
| por_pulse | input | 1 | One-cycle power-up event |
| wake_pulse | input | 1 | One-cycle core wake-up event |
| wdt_pulse | input | 1 | One-cycle watchdog overflow event |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current address |
| ext_rst_in_n | input | 1 | Asynchronous level of the external reset line |
| ext_rst_n_o | output | 1 | Active-low drive of the external reset line |
| proc_rst_o | output | 1 | Processor reset |
| periph_rst_o | output | 1 | Peripheral reset |
| irq_o | output | 1 | Level interrupt on a flagged falling edge |

## Verification
The timing of each result is fixed as follows:
- A keyed write takes effect on the edge that accepts it. Its reset outputs can be seen half a period later and stay up for 2^(N+1) ticked edges.
- A pin change reaches status bit 16 after two edges.
- The sticky flag, the interrupt and the recorded pin cause follow one edge after that.
- A status read clears the flag on its own edge.

The bench drives every input on the falling clock edge and samples half a period after each rising edge. It counts the falling edges on which an output is asserted and compares that count with the computed 2^(N+1), or with twice that value when slow_tick alternates. Pin tests read the status word on each successive cycle after the drop, so every stage of that latency is checked at the cycle where it is due.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam logic [7:0]  UNLOCK   = 8'hA5;
  localparam int unsigned OFS_CMD  = 0;
  localparam int unsigned OFS_STAT = 4;
  localparam int unsigned OFS_MODE = 8;

  typedef enum logic [2:0] {
    CAUSE_POWER = 3'd0,
    CAUSE_WAKE  = 3'd1,
    CAUSE_WDOG  = 3'd2,
    CAUSE_SOFT  = 3'd3,
    CAUSE_PIN   = 3'd4
  } cause_e;
endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic lvl,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_n};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl  = chain_q[STAGES-1];
  assign fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/rstctl_stretch.sv
module rstctl_stretch #(
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             tick,
  output logic             active
);
  localparam int unsigned CNT_W = (1 << LEN_W) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (clr) begin
      cnt_d = '0;
      act_d = 1'b0;
    end else if (start && !act_q) begin
      cnt_d = CNT_W'(1) << (int'(len) + 1);
      act_d = 1'b1;
    end else if (act_q && tick) begin
      if (cnt_q == CNT_W'(1)) begin
        cnt_d = '0;
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
  import rstctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned LEN_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              por_pulse,
  input  logic              wake_pulse,
  input  logic              wdt_pulse,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              ext_rst_in_n,
  output logic              ext_rst_n_o,
  output logic              proc_rst_o,
  output logic              periph_rst_o,
  output logic              irq_o
);
  localparam int unsigned LEN_LSB = 8;

  logic             pin_lvl, pin_fall, busy;
  logic             key_ok, is_cmd, is_stat, is_mode;
  logic             ctrl_cmd, start, mode_wr, stat_rd;
  logic             urst_en_q, urst_en_d, irq_en_q, irq_en_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             sticky_q, sticky_d;
  cause_e           cause_q, cause_d;
  logic [2:0]       req_q, req_d;
  logic             unused_wdata;

  rstctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(ext_rst_in_n), .lvl(pin_lvl), .fall(pin_fall)
  );

  rstctl_stretch #(.LEN_W(LEN_W)) u_stretch (
    .clk(clk), .rst_n(rst_n), .clr(por_pulse), .start(start),
    .len(len_q), .tick(slow_tick), .active(busy)
  );

  // register bus decode
  assign key_ok   = bus_wdata[31:24] == UNLOCK;
  assign is_cmd   = bus_addr == ADDR_W'(OFS_CMD);
  assign is_stat  = bus_addr == ADDR_W'(OFS_STAT);
  assign is_mode  = bus_addr == ADDR_W'(OFS_MODE);
  assign ctrl_cmd = bus_sel && bus_wr && is_cmd && key_ok &&
                    (bus_wdata[0] || bus_wdata[2] || bus_wdata[3]);
  assign start    = ctrl_cmd && !busy && !por_pulse;
  assign mode_wr  = bus_sel && bus_wr && is_mode && key_ok;
  assign stat_rd  = bus_sel && !bus_wr && is_stat;
  assign unused_wdata = ^bus_wdata;

  // next state
  always_comb begin
    urst_en_d = urst_en_q;
    irq_en_d  = irq_en_q;
    len_d     = len_q;
    sticky_d  = sticky_q;
    cause_d   = cause_q;
    req_d     = req_q;

    if (mode_wr) begin
      urst_en_d = bus_wdata[0];
      irq_en_d  = bus_wdata[4];
      len_d     = bus_wdata[LEN_LSB +: LEN_W];
    end
    if (pin_fall)     sticky_d = 1'b1;
    else if (stat_rd) sticky_d = 1'b0;
    if (start)        req_d = {bus_wdata[3], bus_wdata[2], bus_wdata[0]};

    if (por_pulse)                    cause_d = CAUSE_POWER;
    else if (wake_pulse)              cause_d = CAUSE_WAKE;
    else if (wdt_pulse)               cause_d = CAUSE_WDOG;
    else if (pin_fall && urst_en_q)   cause_d = CAUSE_PIN;
    else if (start && bus_wdata[0])   cause_d = CAUSE_SOFT;

    if (por_pulse) begin
      urst_en_d = 1'b0;
      irq_en_d  = 1'b0;
      len_d     = '0;
      sticky_d  = 1'b0;
      req_d     = '0;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      urst_en_q <= 1'b0;
      irq_en_q  <= 1'b0;
      len_q     <= '0;
      sticky_q  <= 1'b0;
      cause_q   <= CAUSE_POWER;
      req_q     <= '0;
    end else begin
      urst_en_q <= urst_en_d;
      irq_en_q  <= irq_en_d;
      len_q     <= len_d;
      sticky_q  <= sticky_d;
      cause_q   <= cause_d;
      req_q     <= req_d;
    end
  end

  // outputs
  assign proc_rst_o   = (busy && req_q[0]) || (urst_en_q && !pin_lvl);
  assign periph_rst_o = (busy && req_q[1]) || (urst_en_q && !pin_lvl);
  assign ext_rst_n_o  = !(busy && req_q[2]);
  assign irq_o        = irq_en_q && sticky_q;

  always_comb begin
    bus_rdata = '0;
    if (is_stat) begin
      bus_rdata[0]    = sticky_q;
      bus_rdata[10:8] = cause_q;
      bus_rdata[16]   = pin_lvl;
      bus_rdata[17]   = busy;
    end else if (is_mode) begin
      bus_rdata[0]                = urst_en_q;
      bus_rdata[4]                = irq_en_q;
      bus_rdata[LEN_LSB +: LEN_W] = len_q;
    end
  end
endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk #(
  parameter int unsigned LEN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             ctrl_cmd,
  input logic             sticky,
  input logic             stat_rd,
  input logic             por_pulse,
  input logic             wake_pulse,
  input logic             wdt_pulse,
  input logic [2:0]       cause,
  input logic             urst_en,
  input logic             irq_en,
  input logic [LEN_W-1:0] len,
  input logic             pin_lvl,
  input logic             ext_rst_n_o,
  input logic             proc_rst_o,
  input logic             irq_o
);
  a_r2_ext_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_rst_n_o |-> busy);

  a_r4_busy_needs_command: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctrl_cmd));

  a_r5_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sticky) |-> $past(stat_rd || por_pulse));

  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> sticky && irq_en);

  a_r8_pin_holds_proc: assert property (@(posedge clk) disable iff (!rst_n)
    (urst_en && !pin_lvl) |-> proc_rst_o);

  a_r9_wdog_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_pulse && !wake_pulse && !por_pulse) |=> cause == 3'd2);

  a_r10_power_clears: assert property (@(posedge clk) disable iff (!rst_n)
    por_pulse |=> cause == 3'd0 && !urst_en && !irq_en && len == '0 && !busy);
endmodule

bind rstctl_top rstctl_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ctrl_cmd(ctrl_cmd),
  .sticky(sticky_q), .stat_rd(stat_rd), .por_pulse(por_pulse),
  .wake_pulse(wake_pulse), .wdt_pulse(wdt_pulse), .cause(cause_q),
  .urst_en(urst_en_q), .irq_en(irq_en_q), .len(len_q), .pin_lvl(pin_lvl),
  .ext_rst_n_o(ext_rst_n_o), .proc_rst_o(proc_rst_o), .irq_o(irq_o)
);

// File: tb/rstctl_top_tb_top.sv
module rstctl_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, slow_tick, por_pulse, wake_pulse, wdt_pulse;
  logic        bus_sel, bus_wr, ext_rst_in_n;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        ext_rst_n_o, proc_rst_o, periph_rst_o, irq_o;
  int          n_chk = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  rstctl_top dut_i (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .por_pulse(por_pulse),
    .wake_pulse(wake_pulse), .wdt_pulse(wdt_pulse), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ext_rst_in_n(ext_rst_in_n),
    .ext_rst_n_o(ext_rst_n_o), .proc_rst_o(proc_rst_o),
    .periph_rst_o(periph_rst_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // all tasks start and end on a falling clock edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input int which);
    if (which == 0) por_pulse = 1'b1;
    if (which == 1) wake_pulse = 1'b1;
    if (which == 2) wdt_pulse = 1'b1;
    @(negedge clk);
    por_pulse = 1'b0; wake_pulse = 1'b0; wdt_pulse = 1'b0;
  endtask

  function automatic logic [2:0] outs();
    return {!ext_rst_n_o, periph_rst_o, proc_rst_o};
  endfunction

  // counts falling edges with any reset output up, checking the pattern
  task automatic measure(input logic [2:0] pat, input bit alt_tick,
                         output int cnt, output int bad);
    cnt = 0; bad = 0;
    while (outs() != 3'b000 && cnt < 5000) begin
      if (outs() != pat) bad++;
      cnt++;
      if (alt_tick) slow_tick = (cnt % 2 == 0);
      @(negedge clk);
    end
    slow_tick = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    logic [31:0] d;
    int cnt, bad;
    rst_n = 1'b0; slow_tick = 1'b1; por_pulse = 1'b0; wake_pulse = 1'b0;
    wdt_pulse = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; ext_rst_in_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 outputs", {28'd0, proc_rst_o, periph_rst_o, ext_rst_n_o, irq_o}, 32'h2);
    rd(4'h4, d); chk("R12 status", d, 32'h0001_0000);
    rd(4'h8, d); chk("R12 mode", d, 32'h0);
    rd(4'h0, d); chk("R12 command reads zero", d, 32'h0);

    // R1 wrong key
    wr(4'h8, 32'h5A00_0311);
    rd(4'h8, d); chk("R1 mode bad key", d, 32'h0);
    wr(4'h0, 32'h5A00_000D);
    chk("R1 command bad key outputs", outs(), 3'b000);
    rd(4'h4, d); chk("R1 command bad key busy", d[17], 1'b0);

    // R2 R3 R9: sweep length and command bits
    for (int n = 0; n < 10; n++) begin
      wr(4'h8, 32'hA500_0000 | (n << 8));
      rd(4'h8, d); chk("R3 mode length readback", d, n << 8);
      for (int c = 0; c < 8; c++) begin
        if (n >= 4 && c != 7) continue;
        pulse(2);
        wr(4'h0, 32'hA500_0000 | (c[2] << 3) | (c[1] << 2) | c[0]);
        if (c == 0) begin
          chk("R2 empty command", outs(), 3'b000);
          rd(4'h4, d); chk("R2 empty command busy", d[17], 1'b0);
        end else begin
          measure(c[2:0], 1'b0, cnt, bad);
          chk("R2 output pattern", bad, 0);
          chk("R3 stretch length", cnt, 32'd1 << (n + 1));
          rd(4'h4, d); chk("R3 busy cleared", d[17], 1'b0);
        end
        rd(4'h4, d); chk("R9 cause after command", d[10:8], c[0] ? 3'd3 : 3'd2);
      end
    end

    // R4 command during busy, R2 busy flag
    wr(4'h8, 32'hA500_0300);
    wr(4'h0, 32'hA500_0001);
    wr(4'h0, 32'hA500_0008);
    chk("R4 no extra output", ext_rst_n_o, 1'b1);
    rd(4'h4, d); chk("R2 busy while running", d[17], 1'b1);
    measure(3'b001, 1'b0, cnt, bad);
    chk("R4 pattern unchanged", bad, 0);
    chk("R4 length not extended", cnt + 2, 16);

    // R11 alternating tick
    wr(4'h8, 32'hA500_0100);
    wr(4'h0, 32'hA500_0004);
    measure(3'b010, 1'b1, cnt, bad);
    chk("R11 half-rate tick", cnt, 8);

    // R5 R6 R7: pin flag only, interrupt enabled
    wr(4'h8, 32'hA500_0010);
    rd(4'h4, d);
    ext_rst_in_n = 1'b0;
    @(negedge clk);
    rd(4'h4, d); chk("R6 level after one edge", d[16], 1'b1);
    rd(4'h4, d); chk("R6 level after two edges", d[16], 1'b0);
    chk("R5 flag not yet set", d[0], 1'b0);
    chk("R7 irq after set", irq_o, 1'b1);
    rd(4'h4, d); chk("R5 flag set despite read", d[0], 1'b1);
    chk("R8 cause kept when disabled", d[10:8], 3'd3);
    chk("R8 no user reset when disabled", proc_rst_o, 1'b0);
    chk("R7 irq drops after read", irq_o, 1'b0);
    rd(4'h4, d); chk("R5 flag cleared by read", d[0], 1'b0);
    ext_rst_in_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'h4, d); chk("R5 rising edge not flagged", d[0], 1'b0);

    // R7 interrupt disabled
    wr(4'h8, 32'hA500_0000);
    ext_rst_in_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 irq masked", irq_o, 1'b0);
    rd(4'h4, d); chk("R5 flag with irq masked", d[0], 1'b1);
    ext_rst_in_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 user reset
    wr(4'h8, 32'hA500_0001);
    ext_rst_in_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 user reset outputs", {proc_rst_o, periph_rst_o}, 2'b11);
    rd(4'h4, d); chk("R8 pin cause", d[10:8], 3'd4);
    ext_rst_in_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 user reset released", {proc_rst_o, periph_rst_o}, 2'b00);

    // R9 R10 cause pulses
    wr(4'h8, 32'hA500_0311);
    pulse(2);
    rd(4'h4, d); chk("R9 watchdog cause", d[10:8], 3'd2);
    rd(4'h8, d); chk("R10 watchdog keeps mode", d, 32'h311);
    pulse(1);
    rd(4'h4, d); chk("R9 wake cause", d[10:8], 3'd1);
    rd(4'h8, d); chk("R10 wake keeps mode", d, 32'h311);
    wake_pulse = 1'b1; wdt_pulse = 1'b1;
    @(negedge clk);
    wake_pulse = 1'b0; wdt_pulse = 1'b0;
    rd(4'h4, d); chk("R9 wake over watchdog", d[10:8], 3'd1);
    wr(4'h0, 32'hA500_0009);
    por_pulse = 1'b1; wdt_pulse = 1'b1;
    @(negedge clk);
    por_pulse = 1'b0; wdt_pulse = 1'b0;
    chk("R10 power-up stops command", outs(), 3'b000);
    rd(4'h4, d); chk("R10 power-up status", d, 32'h0001_0000);
    rd(4'h8, d); chk("R10 power-up clears mode", d, 32'h0);

    report();
  end
endmodule